// File: doc/BRIEF.md
# Edge-Pulse Encoder with Periodic Level Refresh

This block is the transmit side of a pulse-coded link that carries one logic signal across a barrier, where only short pulses pass. The data input is first brought into the clock domain through a synchronizer. Every rising change of the synchronized level produces a one-cycle pulse on a "set" line. Every falling change produces a one-cycle pulse on a "clear" line. The receiving side rebuilds the level from these two pulse streams.

Because a lone pulse can be lost, the block also sends the current level again on the matching line whenever no pulse has gone out for a fixed number of cycles. The far side therefore recovers even when the input stays constant. An enable input stands for the local supply being valid. While it is low, the block sends nothing. When it goes high, the present level is sent at once.

Top module: `edge_pulse_tx`

## Requirements
- R1: A rising change of `data_in` that is first sampled at clock edge k gives `pulse_set` high for one cycle, from edge k+2 (two synchronizer stages, then the output register), while `link_en` stays high.
- R2: A falling change of `data_in` gives `pulse_clr` high for one cycle, with the same latency as R1.
- R3: Each pulse lasts exactly one cycle, and `pulse_set` and `pulse_clr` are never high in the same cycle.
- R4: With `link_en` high and the synchronized level steady, a pulse that encodes that level (set for 1, clear for 0) goes out exactly REFRESH_CYC cycles after the previous pulse, and then again every REFRESH_CYC cycles.
- R5: Every transmitted pulse, including one caused by a data change, restarts the refresh interval. The next refresh comes REFRESH_CYC cycles after that pulse.
- R6: While `link_en` is low, both pulse outputs stay low whatever `data_in` does. The refresh timing does not advance.
- R7: On the first clock edge at which `link_en` is sampled high after being low (or after reset), a pulse that encodes the current synchronized level is registered. It is visible in the cycle after that edge.
- R8: A synchronous active-high `rst` clears the synchronizer, the timer and the remembered level, and holds both pulse outputs low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| data_in | input | 1 | Logic level to transmit (asynchronous to clk) |
| link_en | input | 1 | High when the link may transmit (lockout released) |
| pulse_set | output | 1 | One-cycle pulse: level is now 1 |
| pulse_clr | output | 1 | One-cycle pulse: level is now 0 |

## Verification
The input is driven with single rising and falling changes, long steady stretches that let several refresh pulses go out back to back, and a change in the middle of an interval. The first two patterns separate edge encoding from refresh timing. The mid-interval change shows that the timer restarts on a data pulse rather than running freely. Toggling the input on every cycle and one-cycle glitches check pulse width and show that adjacent pulses never overlap. Changing the input while enable is low, raising enable at both levels, and resetting in the middle of traffic check lockout silence, the immediate send on wake-up and the cleared state.

// File: rtl/edge_tx_pkg.sv
package edge_tx_pkg;

  // Next value of an idle counter: cleared on a send or when not running.
  function automatic int unsigned idle_next(input int unsigned cur,
                                            input logic running,
                                            input logic sent);
    if (!running || sent) return 0;
    return cur + 1;
  endfunction

  // An interval of `period` cycles has elapsed when the counter holds period-1.
  function automatic logic interval_done(input int unsigned cur,
                                         input int unsigned period);
    return (cur + 1) == period;
  endfunction

endpackage

// File: rtl/edge_tx_sync.sv
module edge_tx_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) chain[0] <= 1'b0;
        else     chain[0] <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (rst) chain[g] <= 1'b0;
        else     chain[g] <= chain[g-1];
      end
    end
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/edge_tx_timer.sv
module edge_tx_timer #(
  parameter int REFRESH_CYC = 100
) (
  input  logic clk,
  input  logic rst,
  input  logic running,
  input  logic sent,
  output logic due
);
  import edge_tx_pkg::*;

  localparam int CW = (REFRESH_CYC > 2) ? $clog2(REFRESH_CYC) : 1;

  logic [CW-1:0] idle_q;

  always_ff @(posedge clk) begin
    if (rst) idle_q <= '0;
    else     idle_q <= CW'(idle_next(int'(idle_q), running, sent));
  end

  assign due = running && interval_done(int'(idle_q), REFRESH_CYC);

  // The counter never passes the point where a refresh must have fired.
  AST_IDLE_BOUNDED: assert property (@(posedge clk) disable iff (rst)
    int'(idle_q) < REFRESH_CYC); // R4
endmodule

// File: rtl/edge_tx_encoder.sv
module edge_tx_encoder (
  input  logic clk,
  input  logic rst,
  input  logic level,
  input  logic en,
  input  logic refresh_due,
  output logic armed,
  output logic fire,
  output logic set_o,
  output logic clr_o
);
  logic held_q;
  logic armed_q;
  logic set_q;
  logic clr_q;
  logic wake;
  logic change;
  logic refresh;

  assign wake    = en && !armed_q;
  assign change  = en && armed_q && (level != held_q);
  assign refresh = en && armed_q && refresh_due;
  assign fire    = wake || change || refresh;

  always_ff @(posedge clk) begin
    if (rst) begin
      held_q  <= 1'b0;
      armed_q <= 1'b0;
      set_q   <= 1'b0;
      clr_q   <= 1'b0;
    end else begin
      armed_q <= en;
      set_q   <= fire && level;
      clr_q   <= fire && !level;
      if (fire) held_q <= level;
    end
  end

  assign armed = armed_q;
  assign set_o = set_q;
  assign clr_o = clr_q;

  AST_CHANGE_SENDS: assert property (@(posedge clk) disable iff (rst)
    change |=> (set_q == held_q) && (clr_q == !held_q)); // R1
  AST_SET_ONE_WIDE: assert property (@(posedge clk) disable iff (rst)
    set_q |=> !set_q); // R3
  AST_CLR_ONE_WIDE: assert property (@(posedge clk) disable iff (rst)
    clr_q |=> !clr_q); // R3
  AST_WAKE_SENDS: assert property (@(posedge clk) disable iff (rst)
    $rose(en) |=> (set_q || clr_q)); // R7
endmodule

// File: rtl/edge_pulse_tx.sv
module edge_pulse_tx #(
  parameter int REFRESH_CYC = 100,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic data_in,
  input  logic link_en,
  output logic pulse_set,
  output logic pulse_clr
);
  localparam int GW = $clog2(REFRESH_CYC + 1) + 1;

  logic lvl_sync;
  logic armed;
  logic fire;
  logic due;

  edge_tx_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   (data_in),
    .q   (lvl_sync)
  );

  edge_tx_timer #(.REFRESH_CYC(REFRESH_CYC)) u_timer (
    .clk     (clk),
    .rst     (rst),
    .running (link_en && armed),
    .sent    (fire),
    .due     (due)
  );

  edge_tx_encoder u_enc (
    .clk         (clk),
    .rst         (rst),
    .level       (lvl_sync),
    .en          (link_en),
    .refresh_due (due),
    .armed       (armed),
    .fire        (fire),
    .set_o       (pulse_set),
    .clr_o       (pulse_clr)
  );

  // Output-side gap watch: cycles since the last visible pulse while enabled.
  logic [GW-1:0] gap_q;
  always_ff @(posedge clk) begin
    if (rst || !link_en || pulse_set || pulse_clr) gap_q <= '0;
    else if (gap_q < GW'(REFRESH_CYC)) gap_q <= gap_q + 1'b1;
  end

  AST_NO_OVERLAP: assert property (@(posedge clk) disable iff (rst)
    !(pulse_set && pulse_clr)); // R3
  AST_REFRESH_GAP: assert property (@(posedge clk) disable iff (rst)
    gap_q < GW'(REFRESH_CYC)); // R4
  AST_QUIET_OFF: assert property (@(posedge clk) disable iff (rst)
    !link_en |=> !(pulse_set || pulse_clr)); // R6
  AST_RESET_QUIET: assert property (@(posedge clk)
    rst |=> !(pulse_set || pulse_clr)); // R8
endmodule

// File: tb/tb_edge_pulse_tx.sv
module tb_edge_pulse_tx;
  localparam int REF = 24;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic data_in = 1'b0;
  logic link_en = 1'b0;
  logic pulse_set;
  logic pulse_clr;

  int compared = 0;
  int mismatched = 0;
  int cyc = 0;
  bit done = 1'b0;

  typedef struct {
    int    due;
    bit    is_set;
    string tag;
  } exp_t;
  exp_t sb[$];

  // reference state, kept as a plain history rather than as hardware
  bit  hist[0:1];
  bit  ref_armed;
  bit  ref_sent_lvl;
  int  ref_quiet;
  bit  last_was_change;

  edge_pulse_tx #(.REFRESH_CYC(REF)) dut (
    .clk       (clk),
    .rst       (rst),
    .data_in   (data_in),
    .link_en   (link_en),
    .pulse_set (pulse_set),
    .pulse_clr (pulse_clr)
  );

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  // driver: apply one cycle of stimulus and predict what the next edge sends
  task automatic step(input bit r, input bit d, input bit e);
    @(negedge clk);
    rst = r; data_in = d; link_en = e;
    if (r) begin
      hist[0] = 0; hist[1] = 0; ref_armed = 0; ref_sent_lvl = 0;
      ref_quiet = 0; last_was_change = 0;
    end else begin
      bit lvl;
      bit send;
      string why;
      lvl  = hist[1];
      send = 0;
      why  = "";
      if (e && !ref_armed) begin
        send = 1; why = "R7 wake"; last_was_change = 0;
      end else if (e && lvl != ref_sent_lvl) begin
        send = 1; why = lvl ? "R1 rise" : "R2 fall"; last_was_change = 1;
      end else if (e && ref_quiet == REF - 1) begin
        send = 1;
        why = last_was_change ? "R5 restart" : "R4 refresh";
        last_was_change = 0;
      end
      if (send) begin
        exp_t it;
        it.due = cyc + 1; it.is_set = lvl; it.tag = why;
        sb.push_back(it);
        ref_sent_lvl = lvl;
      end
      ref_quiet = (send || !(e && ref_armed)) ? 0 : ref_quiet + 1;
      ref_armed = e;
      hist[1] = hist[0];
      hist[0] = d;
    end
  endtask

  task automatic run(input int n, input bit d, input bit e);
    for (int i = 0; i < n; i++) step(0, d, e);
  endtask

  // monitor: compare each cycle's outputs with the scoreboard head
  always @(negedge clk) begin
    if (!done) begin
      if (rst && cyc > 1) begin
        compared++;
        if (pulse_set || pulse_clr) begin
          mismatched++;
          $display("FAIL R8 reset: set=%0b clr=%0b expected 0 0", pulse_set, pulse_clr);
        end
      end else if (sb.size() > 0 && sb[0].due == cyc) begin
        exp_t it;
        it = sb.pop_front();
        compared++;
        if (pulse_set != it.is_set || pulse_clr != !it.is_set) begin
          mismatched++;
          $display("FAIL %s at cycle %0d: set=%0b clr=%0b expected %0b %0b",
                   it.tag, cyc, pulse_set, pulse_clr, it.is_set, !it.is_set);
        end
      end else if (pulse_set || pulse_clr) begin
        compared++;
        mismatched++;
        $display("FAIL R3/R6 stray pulse at cycle %0d: set=%0b clr=%0b expected 0 0 (en=%0b)",
                 cyc, pulse_set, pulse_clr, link_en);
      end
      if (pulse_set && pulse_clr) begin
        mismatched++;
        $display("FAIL R3 overlap at cycle %0d: set=1 clr=1 expected not both", cyc);
      end
    end
  end

  initial begin
    hist[0] = 0; hist[1] = 0; ref_armed = 0; ref_sent_lvl = 0;
    ref_quiet = 0; last_was_change = 0;
    for (int i = 0; i < 4; i++) step(1, 1, 1);
    // R6: enable low, input toggles, nothing may go out
    for (int i = 0; i < 10; i++) step(0, i[0], 0);
    run(REF + 5, 1, 0);
    // R7: wake with level 1
    run(4, 1, 1);
    // R4: steady high, several refreshes
    run(3 * REF + 3, 1, 1);
    // R2 then R1
    run(REF / 2, 0, 1);
    run(REF / 3, 1, 1);
    // R5: change mid-interval, then quiet long enough for refreshes
    run(2 * REF + 4, 0, 1);
    // R3: toggle every cycle
    for (int i = 0; i < 12; i++) step(0, i[0], 1);
    // one-cycle glitches
    run(6, 0, 1);
    step(0, 1, 1);
    run(8, 0, 1);
    step(0, 1, 1);
    run(REF + 6, 1, 1);
    // R6 then R7 with level 0
    run(6, 0, 0);
    run(REF + 4, 0, 1);
    // R8: reset in the middle of traffic
    step(0, 1, 1);
    for (int i = 0; i < 3; i++) step(1, 1, 1);
    run(2 * REF + 4, 1, 1);
    run(4, 1, 1);
    if (sb.size() != 0) begin
      compared++;
      mismatched++;
      $display("FAIL R4 pending items: actual %0d left expected 0", sb.size());
    end
    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    #(4 * 20000);
    if (!done) begin
      done = 1'b1;
      compared++;
      mismatched++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end
endmodule